// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Aggregator

This block gathers a wide set of level-sensitive interrupt lines, organised as 32-bit words, and presents them to several processors. Each processor has its own register bank. Every bank sees the same raw line levels but keeps a private mask. Each bank drives one interrupt line to its processor. That line is high while at least one unmasked source in any word is active.

Software talks to each bank over a plain 32-bit register port with read and write strobes, a byte address and write data. Masks change only through two kinds of register. One kind sets mask bits when 1s are written to it. The other kind clears mask bits when 1s are written to it. Bits written as 0 have no effect. Software reads the raw levels and its own mask, and combines them to find the pending sources. Every decision about priority and routing is left to software.

The register groups are packed back to back, so every offset depends on the configured word count `NUM_WORDS` (written N below).

Top module: `irq_agg_top`

## Requirements
- R1: Each bank decodes its byte address as a 32-bit register index (address bits [1:0] are ignored). Indices 0..N-1 are the raw status words, N..2N-1 the mask readback words, 2N..3N-1 the mask-set words and 3N..4N-1 the mask-clear words. Word w of each group sits at index (group base + w), and bits [31:0] of word w cover sources 32w+31..32w.
- R2: A read of a status word returns the synchronised raw input levels for that word, whatever the mask holds, and every bank returns the same value.
- R3: A write to a mask-set word sets the mask bits where the write data is 1 and leaves the bits where it is 0 unchanged.
- R4: A write to a mask-clear word clears the mask bits where the write data is 1 and leaves the bits where it is 0 unchanged.
- R5: A read of a mask readback word returns that bank's current mask, with 1 meaning masked.
- R6: Each bank's mask changes only through its own port. Writes made in the same cycle to different banks, including a set in one bank and a clear in another for the same bit, each take effect only in their own bank.
- R7: A bank's interrupt output is a register holding the OR, over all words, of (status AND NOT mask). It reflects a mask write on the second clock edge after the write is sampled.
- R8: While reset is high and after it ends, every mask bit of every bank is 1, every interrupt output is 0 and read data is 0.
- R9: Writes to status words, and writes to indices at or above 4N, change no state. Reads of indices at or above 4N return 0.
- R10: Read data is registered. It appears in the cycle after the read strobe and is 0 in any cycle not preceded by a read.
- R11: Interrupt inputs pass through two flip-flops before the status words. A change on an unmasked input therefore reaches the output on the third clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_WORDS*32 | Level-sensitive interrupt sources, bit 32w+b is word w bit b |
| bus_wr | input | NUM_CPUS | Per-bank write strobe |
| bus_rd | input | NUM_CPUS | Per-bank read strobe |
| bus_addr | input | NUM_CPUS*ADDR_W | Per-bank byte address, bank c in slice c |
| bus_wdata | input | NUM_CPUS*32 | Per-bank write data |
| bus_rdata | output | NUM_CPUS*32 | Per-bank registered read data |
| irq_out | output | NUM_CPUS | Per-bank registered interrupt request |

## Verification
The hardest case to reach from the ports is two banks updating the same mask bit in one clock cycle, with one bank setting the bit and the other clearing it. A dedicated bench task drives both ports on the same edge and then reads back both masks. It also checks which output stays high. A second hard case is that accesses outside the map must not alias into the set or clear groups. The stimulus writes all-ones to out-of-range indices whose values modulo the group size would land on a set or clear register. It then reads back the masks, which must be unchanged, and the outputs.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int SRC_PER_WORD = 32;

  typedef enum logic [1:0] {
    GRP_STATUS = 2'd0,
    GRP_MASKRD = 2'd1,
    GRP_MSET   = 2'd2,
    GRP_MCLR   = 2'd3
  } reg_grp_e;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;

endmodule

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8,
  localparam int IW       = ADDR_W - 2,
  localparam int WIDX     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [IW-1:0]   word_addr,
  output logic            hit,
  output reg_grp_e        grp,
  output logic [WIDX-1:0] word
);

  localparam logic [IW-1:0] BASE1 = IW'(NUM_WORDS);
  localparam logic [IW-1:0] BASE2 = IW'(2 * NUM_WORDS);
  localparam logic [IW-1:0] BASE3 = IW'(3 * NUM_WORDS);
  localparam logic [IW-1:0] BASE4 = IW'(4 * NUM_WORDS);

  logic [IW-1:0] offs;
  logic          unused_offs_hi;

  always_comb begin
    hit  = word_addr < BASE4;
    grp  = GRP_STATUS;
    offs = word_addr;
    if (word_addr >= BASE3) begin
      grp  = GRP_MCLR;
      offs = word_addr - BASE3;
    end else if (word_addr >= BASE2) begin
      grp  = GRP_MSET;
      offs = word_addr - BASE2;
    end else if (word_addr >= BASE1) begin
      grp  = GRP_MASKRD;
      offs = word_addr - BASE1;
    end
  end

  assign word           = offs[WIDX-1:0];
  assign unused_offs_hi = ^offs;

endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8,
  localparam int IW       = ADDR_W - 2,
  localparam int NSRC     = NUM_WORDS * SRC_PER_WORD,
  localparam int WIDX     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status,
  input  logic            wr,
  input  logic            rd,
  input  logic [IW-1:0]   word_addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            irq_out
);

  logic            sel_hit;
  reg_grp_e        sel_grp;
  logic [WIDX-1:0] sel_word;

  irq_agg_decode #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_dec (
    .word_addr (word_addr),
    .hit       (sel_hit),
    .grp       (sel_grp),
    .word      (sel_word)
  );

  logic [31:0]          mask_q   [NUM_WORDS];
  logic [31:0]          status_w [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_act;
  logic [31:0]          rdata_q;
  logic                 irq_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign status_w[w] = status[w*SRC_PER_WORD +: SRC_PER_WORD];
    assign word_act[w] = |(status_w[w] & ~mask_q[w]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NUM_WORDS; w++) mask_q[w] <= '1;
    end else if (wr && sel_hit) begin
      if (sel_grp == GRP_MSET)
        mask_q[sel_word] <= mask_q[sel_word] | wdata;
      else if (sel_grp == GRP_MCLR)
        mask_q[sel_word] <= mask_q[sel_word] & ~wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd && sel_hit) begin
      case (sel_grp)
        GRP_STATUS: rdata_q <= status_w[sel_word];
        GRP_MASKRD: rdata_q <= mask_q[sel_word];
        default:    rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |word_act;
  end

  assign rdata   = rdata_q;
  assign irq_out = irq_q;

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  localparam int NSRC     = NUM_WORDS * SRC_PER_WORD
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC-1:0]        irq_in,
  input  logic [NUM_CPUS-1:0]    bus_wr,
  input  logic [NUM_CPUS-1:0]    bus_rd,
  input  logic [NUM_CPUS*ADDR_W-1:0] bus_addr,
  input  logic [NUM_CPUS*32-1:0] bus_wdata,
  output logic [NUM_CPUS*32-1:0] bus_rdata,
  output logic [NUM_CPUS-1:0]    irq_out
);

  logic [NSRC-1:0] status;

  irq_agg_sync #(
    .WIDTH (NSRC)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (irq_in),
    .sync_out (status)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic unused_lsb;
    assign unused_lsb = ^bus_addr[c*ADDR_W +: 2];

    irq_agg_bank #(
      .NUM_WORDS (NUM_WORDS),
      .ADDR_W    (ADDR_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .status    (status),
      .wr        (bus_wr[c]),
      .rd        (bus_rd[c]),
      .word_addr (bus_addr[c*ADDR_W+2 +: ADDR_W-2]),
      .wdata     (bus_wdata[c*32 +: 32]),
      .rdata     (bus_rdata[c*32 +: 32]),
      .irq_out   (irq_out[c])
    );
  end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_WORDS = 2,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  localparam int NSRC     = NUM_WORDS * 32,
  localparam int IW       = ADDR_W - 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NSRC-1:0]            irq_in,
  input logic [NUM_CPUS-1:0]        bus_wr,
  input logic [NUM_CPUS-1:0]        bus_rd,
  input logic [NUM_CPUS*ADDR_W-1:0] bus_addr,
  input logic [NUM_CPUS*32-1:0]     bus_wdata,
  input logic [NUM_CPUS*32-1:0]     bus_rdata,
  input logic [NUM_CPUS-1:0]        irq_out
);

  localparam logic [IW-1:0] B1 = IW'(NUM_WORDS);
  localparam logic [IW-1:0] B2 = IW'(2 * NUM_WORDS);
  localparam logic [IW-1:0] B3 = IW'(3 * NUM_WORDS);
  localparam logic [IW-1:0] B4 = IW'(4 * NUM_WORDS);

  // R8
  reset_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_out == '0));

  // R11
  quiet_in_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_in, 3) == '0) |-> (irq_out == '0));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [IW-1:0] ix, w_rd, w_set, w_clr;
    logic          in_rd, in_set, in_clr;
    logic [31:0]   rdv, wdv;
    logic          unused_lsb;

    assign ix         = bus_addr[c*ADDR_W+2 +: IW];
    assign unused_lsb = ^bus_addr[c*ADDR_W +: 2];
    assign in_rd      = (ix >= B1) && (ix < B2);
    assign in_set     = (ix >= B2) && (ix < B3);
    assign in_clr     = (ix >= B3) && (ix < B4);
    assign w_rd       = ix - B1;
    assign w_set      = ix - B2;
    assign w_clr      = ix - B3;
    assign rdv        = bus_rdata[c*32 +: 32];
    assign wdv        = bus_wdata[c*32 +: 32];

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_rd[c] |=> (rdv == '0));

    // R9
    oor_read_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd[c] && (ix >= B4)) |=> (rdv == '0));

    // R3
    set_readback_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd[c] && in_rd && $past(!rst) && $past(bus_wr[c]) && $past(in_set)
       && ($past(w_set) == w_rd))
      |=> ((rdv & $past(wdv, 2)) == $past(wdv, 2)));

    // R4
    clr_readback_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd[c] && in_rd && $past(!rst) && $past(bus_wr[c]) && $past(in_clr)
       && ($past(w_clr) == w_rd))
      |=> ((rdv & $past(wdv, 2)) == '0));
  end

endmodule

bind irq_agg_top irq_agg_chk #(
  .NUM_WORDS (NUM_WORDS),
  .NUM_CPUS  (NUM_CPUS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out)
);

// File: tb/irq_agg_top_test.sv
module irq_agg_top_test;

  localparam int NW = 2;
  localparam int NC = 2;
  localparam int AW = 8;
  localparam int NS = NW * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NS-1:0]    irq_in = '0;
  logic [NC-1:0]    bus_wr = '0;
  logic [NC-1:0]    bus_rd = '0;
  logic [NC*AW-1:0] bus_addr = '0;
  logic [NC*32-1:0] bus_wdata = '0;
  logic [NC*32-1:0] bus_rdata;
  logic [NC-1:0]    irq_out;

  irq_agg_top #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] mdl [NC][NW];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_upd(int c, int a, logic [31:0] d);
    int ix = a >> 2;
    if (ix >= 2*NW && ix < 3*NW) mdl[c][ix-2*NW] = mdl[c][ix-2*NW] | d;
    else if (ix >= 3*NW && ix < 4*NW) mdl[c][ix-3*NW] = mdl[c][ix-3*NW] & ~d;
  endtask

  task automatic wr1(int c, int a, logic [31:0] d);
    @(negedge clk);
    bus_wr[c] = 1'b1;
    bus_addr[c*AW +: AW] = AW'(a);
    bus_wdata[c*32 +: 32] = d;
    @(negedge clk);
    bus_wr[c] = 1'b0;
    model_upd(c, a, d);
  endtask

  task automatic wr2(int a0, logic [31:0] d0, int a1, logic [31:0] d1);
    @(negedge clk);
    bus_wr = '1;
    bus_addr[0 +: AW] = AW'(a0);
    bus_addr[AW +: AW] = AW'(a1);
    bus_wdata = {d1, d0};
    @(negedge clk);
    bus_wr = '0;
    model_upd(0, a0, d0);
    model_upd(1, a1, d1);
  endtask

  task automatic rd1(int c, int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd[c] = 1'b1;
    bus_addr[c*AW +: AW] = AW'(a);
    @(negedge clk);
    bus_rd[c] = 1'b0;
    d = bus_rdata[c*32 +: 32];
  endtask

  function automatic logic exp_out(int c);
    logic r = 1'b0;
    for (int w = 0; w < NW; w++) r |= |(irq_in[w*32 +: 32] & ~mdl[c][w]);
    return r;
  endfunction

  function automatic logic [31:0] exp_vec();
    logic [31:0] v = '0;
    for (int c = 0; c < NC; c++) v[c] = exp_out(c);
    return v;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R8 irq_out after reset", 32'(irq_out), 32'h0);
    check("R10 rdata idle", bus_rdata[31:0], 32'h0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd1(c, 4*(NW+w), d);
        check("R8 R5 mask after reset", d, 32'hFFFF_FFFF);
      end
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk);
    irq_in = {32'h0000_0020, 32'hA5A5_0F0F};
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd1(c, 4*w, d);
        check("R2 status read", d, irq_in[w*32 +: 32]);
      end
    check("R7 all masked output", 32'(irq_out), 32'h0);
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    wr1(0, 4*(3*NW+1), 32'h20);
    check("R7 output one cycle late", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R7 R6 output after clear", 32'(irq_out), exp_vec());
    check("R7 expected pattern", 32'(irq_out), 32'h1);
    rd1(0, 4*(NW+1), d);
    check("R4 R5 readback after clear", d, 32'hFFFF_FFDF);
    rd1(1, 4*(NW+1), d);
    check("R6 other bank untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_set();
    logic [31:0] d;
    wr1(0, 4*(2*NW+1), 32'h20);
    @(negedge clk);
    check("R3 set masks output", 32'(irq_out), 32'h0);
    wr1(1, 4*(3*NW), 32'hFFFF_0000);
    rd1(1, 4*NW, d);
    check("R4 partial clear", d, 32'h0000_FFFF);
    wr1(1, 4*(2*NW), 32'h0F00_0000);
    rd1(1, 4*NW, d);
    check("R3 partial set keeps zeros", d, 32'h0F00_FFFF);
    check("R7 bank1 output", 32'(irq_out), 32'h2);
  endtask

  task automatic t_indep();
    logic [31:0] d;
    wr1(0, 4*(3*NW), 32'h1);
    @(negedge clk);
    check("R7 bank0 bit0 unmasked", 32'(irq_out), 32'h3);
    wr2(4*(2*NW), 32'h1, 4*(3*NW), 32'h1);
    @(negedge clk);
    rd1(0, 4*NW, d);
    check("R6 bank0 set same cycle", d, 32'hFFFF_FFFF);
    rd1(1, 4*NW, d);
    check("R6 bank1 clear same cycle", d, 32'h0F00_FFFE);
    check("R6 outputs after split write", 32'(irq_out), exp_vec());
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr1(0, 0, 32'hFFFF_FFFF);
    wr1(1, 4, 32'h0);
    wr1(1, 4*(4*NW+2), 32'hFFFF_FFFF);
    wr1(1, 4*(6*NW), 32'hFFFF_FFFF);
    wr1(0, 4*(7*NW), 32'hFFFF_FFFF);
    @(negedge clk);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        rd1(c, 4*(NW+w), d);
        check("R9 mask unchanged by ignored writes", d, mdl[c][w]);
      end
    rd1(1, 4*(4*NW), d);
    check("R9 out of range read", d, 32'h0);
    rd1(0, 4*(7*NW+1), d);
    check("R9 out of range read high", d, 32'h0);
    rd1(0, 0, d);
    check("R9 R2 status not writable", d, 32'hA5A5_0F0F);
    check("R9 outputs unchanged", 32'(irq_out), 32'h2);
  endtask

  task automatic t_sync();
    @(negedge clk);
    irq_in = '0;
    repeat (4) @(negedge clk);
    check("R11 quiet inputs", 32'(irq_out), 32'h0);
    irq_in[16] = 1'b1;
    @(negedge clk);
    check("R11 edge1", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R11 edge2", 32'(irq_out), 32'h0);
    @(negedge clk);
    check("R11 edge3 rises", 32'(irq_out), 32'h2);
    irq_in[16] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R11 still high edge2", 32'(irq_out), 32'h2);
    @(negedge clk);
    check("R11 falls edge3", 32'(irq_out), 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    rd1(1, 4*NW + 3, d);
    check("R1 low address bits ignored", d, 32'h0F00_FFFE);
    @(negedge clk);
    check("R10 rdata zero without read", bus_rdata[63:32], 32'h0);
    wr1(1, 4*(3*NW+1) + 1, 32'h8);
    rd1(1, 4*(NW+1) + 2, d);
    check("R1 word1 clear and readback", d, 32'hFFFF_FFF7);
  endtask

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) mdl[c][w] = '1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_status();
    t_unmask();
    t_set();
    t_indep();
    t_ignored();
    t_sync();
    t_addr();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule